// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block drives the direction-enable pin of an external half-duplex RS-485 transceiver from the state of a UART transmit path. It watches two transmit-path conditions: whether the transmit queue holds data, and whether the serializer is still shifting a character. While either condition holds, the direction pin selects transmit. When both end, the pin stays at transmit for a guard interval of a fixed number of bit periods, so the final stop bit has time to pass through the transceiver. After the guard interval the pin returns to receive.

Bit periods are counted from a one-cycle baud tick supplied by the baud generator. One configuration input enables the function. A second configuration input picks which logic level on the pin means transmit. The controller is a three-state machine:

- `ST_RECV` is idle, with the pin at the receive level.
- `ST_SEND` means data is queued or shifting.
- `ST_GUARD` means both have drained and the guard counter is running.

The transitions are:

- RECV to SEND on transmit activity.
- SEND to GUARD when the queue and the shifter are both empty.
- GUARD to SEND when new activity arrives, which cancels the guard.
- GUARD to RECV on the last guard tick.
- Any state to RECV when the enable input is low.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: With `cfg_enable`=0, from the next clock edge `dir_out` sits at the receive level and `guard_active` is 0, whatever the queue, shifter and tick inputs do.
- R2: With `cfg_invert`=0, transmit is `dir_out`=1 and receive is 0. With `cfg_invert`=1 the levels swap. A change of `cfg_invert` shows on `dir_out` at the next clock edge and leaves the state and guard count unchanged.
- R3: With `cfg_enable`=1, if `txq_empty`=0 or `shift_busy`=1 is sampled at a clock edge, `dir_out` is at the transmit level after that edge.
- R4: `dir_out` returns to the receive level only after a clock edge at which both `txq_empty`=1 and `shift_busy`=0 are sampled.
- R5: After the edge that first samples both `txq_empty`=1 and `shift_busy`=0, `guard_active`=1 and `dir_out` stays at transmit. On the edge that samples the GUARD_BITS-th `bit_tick` (default 3) while in the guard state, `dir_out` goes to receive and `guard_active` to 0.
- R6: Clock cycles without `bit_tick` do not advance the guard interval, however many there are.
- R7: Transmit activity (`txq_empty`=0 or `shift_busy`=1) sampled during the guard interval clears `guard_active` at that edge and keeps `dir_out` at transmit. The next guard interval then counts a full GUARD_BITS ticks again.
- R8: A synchronous reset (`rst`=1 at an edge) puts the machine in RECV with the counter cleared, `guard_active`=0 and `dir_out` at the receive level for the current `cfg_invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | 1 enables hardware direction control |
| cfg_invert | input | 1 | 0: transmit drives 1; 1: transmit drives 0 |
| txq_empty | input | 1 | Transmit queue is empty |
| shift_busy | input | 1 | Serializer is still shifting a character |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| dir_out | output | 1 | Registered direction pin for the transceiver |
| guard_active | output | 1 | 1 while the guard interval runs |

## Verification
The bench builds the block with the default GUARD_BITS of 3. With that value, every position at which new activity can cancel the guard (before each of the three ticks, or never) can be swept under both polarities. Each sweep is repeated with 0, 1 and 3 idle clocks between ticks. This covers release timing, cancellation, tick-only counting and polarity together. Expected levels are computed from the tick count the bench itself has issued.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
    typedef enum logic [1:0] {
        ST_RECV  = 2'd0,
        ST_SEND  = 2'd1,
        ST_GUARD = 2'd2
    } dir_state_t;
endpackage

// File: rtl/rs485_guard_cnt.sv
module rs485_guard_cnt #(
    parameter int GUARD_BITS = 3,
    localparam int CNT_W = (GUARD_BITS > 1) ? $clog2(GUARD_BITS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CNT_W'(GUARD_BITS - 1));

    // R5: the count never passes the guard length
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < GUARD_BITS);

    // R6: without a tick the count holds
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/rs485_dir_drive.sv
module rs485_dir_drive (
    input  logic clk,
    input  logic rst,
    input  logic tx_next,
    input  logic invert,
    output logic dir_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_out <= invert;
        end else begin
            dir_out <= tx_next ^ invert;
        end
    end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int GUARD_BITS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_enable,
    input  logic cfg_invert,
    input  logic txq_empty,
    input  logic shift_busy,
    input  logic bit_tick,
    output logic dir_out,
    output logic guard_active
);
    dir_state_t state_q, state_d;
    logic       tx_activity;
    logic       guard_last;
    logic       cnt_clear;

    assign tx_activity = !txq_empty || shift_busy;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECV: begin
                if (cfg_enable && tx_activity) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (!cfg_enable)       state_d = ST_RECV;
                else if (!tx_activity) state_d = ST_GUARD;
            end
            ST_GUARD: begin
                if (!cfg_enable)                   state_d = ST_RECV;
                else if (tx_activity)              state_d = ST_SEND;
                else if (bit_tick && guard_last)   state_d = ST_RECV;
            end
            default: state_d = ST_RECV;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RECV;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_clear = (state_q != ST_GUARD) || (state_d != ST_GUARD);

    rs485_guard_cnt #(.GUARD_BITS(GUARD_BITS)) u_guard_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (cnt_clear),
        .advance (bit_tick),
        .last    (guard_last)
    );

    // registered outputs
    rs485_dir_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .tx_next (state_d != ST_RECV),
        .invert  (cfg_invert),
        .dir_out (dir_out)
    );

    always_comb begin
        guard_active = (state_q == ST_GUARD);
    end

    // R1: disabled means receive level next edge
    p_rx_when_off_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> (dir_out == $past(cfg_invert)) && !guard_active);

    // R3: activity forces transmit level
    p_tx_when_active_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && tx_activity) |=> (dir_out != $past(cfg_invert)));

    // R5: SEND never releases straight to RECV while enabled
    p_via_guard_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND && cfg_enable) |=> (state_q != ST_RECV));

    // R6: guard holds through cycles without a tick
    p_guard_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (guard_active && !bit_tick && cfg_enable && !tx_activity) |=> guard_active);

    // R8: reset yields receive level and no guard
    p_reset_state_r8: assert property (@(posedge clk)
        $past(rst) |-> (dir_out == $past(cfg_invert)) && !guard_active);
endmodule

// File: tb/test_rs485_dir_ctrl.sv
module test_rs485_dir_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int GUARD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_enable = 1'b0;
    logic cfg_invert = 1'b0;
    logic txq_empty = 1'b1;
    logic shift_busy = 1'b0;
    logic bit_tick = 1'b0;
    logic dir_out;
    logic guard_active;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rs485_dir_ctrl #(.GUARD_BITS(GUARD)) i_rs485_dir_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg_enable   (cfg_enable),
        .cfg_invert   (cfg_invert),
        .txq_empty    (txq_empty),
        .shift_busy   (shift_busy),
        .bit_tick     (bit_tick),
        .dir_out      (dir_out),
        .guard_active (guard_active)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic expect_out(input logic exp_dir, input logic exp_guard, input string req);
        checks++;
        if (dir_out !== exp_dir || guard_active !== exp_guard) begin
            errors++;
            $display("FAIL %s: dir_out=%b guard_active=%b expected dir_out=%b guard_active=%b",
                     req, dir_out, guard_active, exp_dir, exp_guard);
        end
    endtask

    // one frame: activity, drain, guard with optional cancellation before tick cancel_k
    task automatic run_frame(input logic pol, input int spacing, input int cancel_k);
        int seen = 0;
        bit cancelled = 0;
        cfg_enable = 1'b1; cfg_invert = pol;
        txq_empty = 1'b0; shift_busy = 1'b0; bit_tick = 1'b0;
        cyc(); expect_out(!pol, 1'b0, "R3");
        txq_empty = 1'b1; shift_busy = 1'b1;
        cyc(); expect_out(!pol, 1'b0, "R3");
        bit_tick = 1'b1;
        cyc(); expect_out(!pol, 1'b0, "R4");
        bit_tick = 1'b0; shift_busy = 1'b0;
        cyc(); expect_out(!pol, 1'b1, "R5");
        while (seen < GUARD) begin
            for (int i = 0; i < spacing; i++) begin
                cyc(); expect_out(!pol, 1'b1, "R6");
            end
            if (!cancelled && seen == cancel_k) begin
                shift_busy = 1'b1;
                cyc(); expect_out(!pol, 1'b0, "R7");
                shift_busy = 1'b0;
                cyc(); expect_out(!pol, 1'b1, "R7");
                seen = 0;
                cancelled = 1;
                continue;
            end
            bit_tick = 1'b1;
            cyc();
            bit_tick = 1'b0;
            seen++;
            if (seen == GUARD) expect_out(pol, 1'b0, "R5");
            else               expect_out(!pol, 1'b1, "R5");
        end
        cyc(); expect_out(pol, 1'b0, "R4");
        bit_tick = 1'b1;
        cyc(); expect_out(pol, 1'b0, "R4");
        bit_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset with both polarities
        for (int p = 0; p < 2; p++) begin
            rst = 1'b1; cfg_invert = p[0]; cfg_enable = 1'b1; txq_empty = 1'b0;
            cyc(); cyc();
            expect_out(p[0], 1'b0, "R8");
        end
        txq_empty = 1'b1; cfg_enable = 1'b0;
        cyc();
        rst = 1'b0;
        cyc(); expect_out(1'b1, 1'b0, "R8");

        // R1: disabled ignores activity under both polarities
        for (int p = 0; p < 2; p++) begin
            cfg_invert = p[0];
            for (int v = 0; v < 8; v++) begin
                txq_empty = v[0]; shift_busy = v[1]; bit_tick = v[2];
                cyc(); expect_out(p[0], 1'b0, "R1");
            end
        end
        bit_tick = 1'b0; txq_empty = 1'b1; shift_busy = 1'b0;

        // R2: polarity flips in idle track on next edge
        cfg_enable = 1'b1;
        for (int p = 0; p < 4; p++) begin
            cfg_invert = p[0];
            cyc(); expect_out(p[0], 1'b0, "R2");
        end

        // R5/R6/R7 sweep: polarity x spacing x cancel position
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 4; s++) begin
                if (s == 2) continue;
                for (int c = 0; c <= GUARD; c++) begin
                    run_frame(p[0], s, c);
                end
            end
        end

        // R2: polarity flip during guard keeps state and count
        run_frame(1'b0, 0, GUARD);
        cfg_invert = 1'b0; txq_empty = 1'b0;
        cyc(); expect_out(1'b1, 1'b0, "R2");
        txq_empty = 1'b1;
        cyc(); expect_out(1'b1, 1'b1, "R2");
        bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
        expect_out(1'b1, 1'b1, "R2");
        cfg_invert = 1'b1;
        cyc(); expect_out(1'b0, 1'b1, "R2");
        bit_tick = 1'b1; cyc();
        expect_out(1'b0, 1'b1, "R2");
        cyc(); bit_tick = 1'b0;
        expect_out(1'b1, 1'b0, "R2");

        // R1: disable mid-transmission releases at next edge
        cfg_invert = 1'b0; txq_empty = 1'b0;
        cyc(); expect_out(1'b1, 1'b0, "R3");
        cfg_enable = 1'b0;
        cyc(); expect_out(1'b0, 1'b0, "R1");
        txq_empty = 1'b1; cfg_enable = 1'b1;
        cyc(); expect_out(1'b0, 1'b0, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule